// File: doc/BRIEF.md
# Memory Domain and Access Permission Gate

This block decides, within the same cycle, whether a translated memory access may go ahead. It receives the attributes of the descriptor that translated the address (the number of the domain the region belongs to, two access-permission bits and an execute-never bit), together with the privilege level of the requester and the kind of access: data read, data write or instruction fetch. It answers with an allow signal, or with a fault code that tells a domain fault apart from a permission fault and from an execute-never fault.

The decision takes two steps. A 32-bit control word holds one 2-bit mode per domain. That mode can let every access through, refuse every access, or hand the decision to the descriptor. Only in that last case are the permission bits, the privilege level and the execute-never bit looked at. The control word is loaded through a simple synchronous write port. A write takes effect on the decision from the cycle that follows it.

Top module: `dom_perm_gate`

## Requirements
- R1: When `ctl_wr_en` is high at a rising clock edge, the control word takes `ctl_wr_data`, and decisions from the next cycle on use the new value. While `ctl_wr_en` is low, the control word keeps its value.
- R2: A synchronous active-low reset clears the control word to all zeros, so every domain then refuses all accesses (fault code 01).
- R3: The mode of domain d is held in control bits 2d+1:2d. Modes 00 and the reserved 10 refuse every access: `acc_allow`=0 and `acc_fault`=01, whatever the permission bits, execute-never bit, privilege and access kind.
- R4: Mode 11 lets every access through, with `acc_allow`=1 and `acc_fault`=00. The permission bits, the execute-never bit, the privilege level and the access kind are all ignored.
- R5: Under mode 01, permission bits 00 fault every access with code 10.
- R6: Under mode 01, permission bits 01 allow any privileged access and fault every unprivileged access with code 10.
- R7: Under mode 01, permission bits 10 allow any privileged access. An unprivileged read or fetch is allowed, and an unprivileged write faults with code 10.
- R8: Under mode 01, permission bits 11 allow every access.
- R9: Under mode 01, an instruction fetch with `acc_xn`=1 faults with code 11 when the permission bits would otherwise allow it. A permission failure is reported as 10 ahead of execute-never. Reads and writes ignore `acc_xn`.
- R10: Access kind encoding: 00 read, 01 write, 10 instruction fetch. The unused value 11 is treated as a write.
- R11: Fault code encoding is 00 none, 01 domain, 10 permission, 11 execute-never. `acc_allow` is 1 exactly when `acc_fault` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Load the control word |
| ctl_wr_data | input | 2*DOMAINS (32) | Value to load into the control word |
| acc_domain | input | clog2(DOMAINS) (4) | Domain number from the descriptor |
| acc_ap | input | 2 | Access-permission bits from the descriptor |
| acc_xn | input | 1 | Execute-never bit from the descriptor |
| acc_priv | input | 1 | 1 = privileged requester |
| acc_kind | input | 2 | Access kind (read, write, fetch) |
| acc_allow | output | 1 | Access may proceed |
| acc_fault | output | 2 | Fault code |

## Verification
The bench builds the block with its defaults: sixteen domains and a 32-bit control word. This puts the lowest and highest mode fields (bits 1:0 and 31:30) within reach. A single control word loads all four mode values at once, so deny, reserved, check and allow-all domains can be compared side by side without reloading. The vector table then walks every permission encoding under both privilege levels and all four access-kind values. Directed steps cover the one-cycle write latency, a held write port and a reset in the middle of the run.

// File: rtl/dpc_pkg.sv
// Package: shared encodings for the domain and permission gate.
// Assumes two bits per domain mode and two bits per permission field.
package dpc_pkg;

    typedef enum logic [1:0] {
        DM_DENY  = 2'b00,
        DM_CHECK = 2'b01,
        DM_RSVD  = 2'b10,
        DM_ALL   = 2'b11
    } dom_mode_e;

    typedef enum logic [1:0] {
        AP_NONE    = 2'b00,
        AP_PRIV    = 2'b01,
        AP_USER_RO = 2'b10,
        AP_FULL    = 2'b11
    } ap_e;

    typedef enum logic [1:0] {
        K_READ  = 2'b00,
        K_WRITE = 2'b01,
        K_FETCH = 2'b10,
        K_RSVD  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        F_NONE   = 2'b00,
        F_DOMAIN = 2'b01,
        F_PERM   = 2'b10,
        F_XN     = 2'b11
    } fault_e;

    localparam int MODE_W = 2;

endpackage

// File: rtl/dpc_ctl_reg.sv
// Module: control word register.
// Holds one mode field per domain. It loads on a write strobe and clears to
// zero (deny everywhere) under synchronous active-low reset.
module dpc_ctl_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    // Load or clear the control word on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data;
    end
endmodule

// File: rtl/dpc_mode_mux.sv
// Module: domain mode selector.
// Splits the control word into per-domain fields and picks the one named by
// the descriptor. An index beyond DOMAINS selects deny.
module dpc_mode_mux
    import dpc_pkg::*;
#(
    parameter int DOMAINS = 16,
    localparam int DOM_W  = (DOMAINS > 1) ? $clog2(DOMAINS) : 1,
    localparam int CTRL_W = MODE_W * DOMAINS
) (
    input  logic [CTRL_W-1:0] ctl,
    input  logic [DOM_W-1:0]  dom_idx,
    output dom_mode_e         mode
);
    logic [MODE_W-1:0] fields [DOMAINS];

    for (genvar g = 0; g < DOMAINS; g++) begin : g_field
        assign fields[g] = ctl[MODE_W*g +: MODE_W];
    end

    // Select the mode of the addressed domain.
    always_comb begin
        if (int'(dom_idx) < DOMAINS) mode = dom_mode_e'(fields[dom_idx]);
        else                         mode = DM_DENY;
    end
endmodule

// File: rtl/dpc_perm_eval.sv
// Module: descriptor permission evaluator.
// Judges the permission bits against privilege and access kind, and flags
// a fetch from an execute-never region. The unused kind value counts as a write.
module dpc_perm_eval
    import dpc_pkg::*;
(
    input  logic [1:0] ap,
    input  logic       xn,
    input  logic       priv,
    input  logic [1:0] kind,
    output logic       perm_ok,
    output logic       xn_hit
);
    kind_e k;
    logic  is_write;

    // Classify the access kind.
    always_comb begin
        k        = kind_e'(kind);
        is_write = (k == K_WRITE) || (k == K_RSVD);
    end

    // Decide permission from the descriptor's permission bits.
    always_comb begin
        unique case (ap_e'(ap))
            AP_NONE:    perm_ok = 1'b0;
            AP_PRIV:    perm_ok = priv;
            AP_USER_RO: perm_ok = priv || !is_write;
            default:    perm_ok = 1'b1;
        endcase
    end

    // Flag an instruction fetch from a non-executable region.
    always_comb xn_hit = (k == K_FETCH) && xn;
endmodule

// File: rtl/dpc_fault_pick.sv
// Module: fault priority encoder.
// The domain mode is decided first. Only the check mode consults the permission
// and execute-never results, with permission ahead of execute-never.
module dpc_fault_pick
    import dpc_pkg::*;
(
    input  dom_mode_e  mode,
    input  logic       perm_ok,
    input  logic       xn_hit,
    output logic [1:0] fault,
    output logic       allow
);
    fault_e f;

    // Rank the fault causes.
    always_comb begin
        unique case (mode)
            DM_ALL:   f = F_NONE;
            DM_CHECK: begin
                if (!perm_ok)    f = F_PERM;
                else if (xn_hit) f = F_XN;
                else             f = F_NONE;
            end
            default:  f = F_DOMAIN;
        endcase
    end

    // Drive the outputs from the ranked fault.
    always_comb begin
        fault = f;
        allow = (f == F_NONE);
    end
endmodule

// File: rtl/dom_perm_gate.sv
// Module: domain and access permission gate (top).
// Holds the per-domain control word and decides each access combinationally
// from it and the descriptor attributes. Expects the inputs stable before
// the sampling point. The only state is the control word.
module dom_perm_gate #(
    parameter int DOMAINS = 16,
    localparam int DOM_W  = (DOMAINS > 1) ? $clog2(DOMAINS) : 1,
    localparam int CTRL_W = dpc_pkg::MODE_W * DOMAINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [CTRL_W-1:0] ctl_wr_data,
    input  logic [DOM_W-1:0]  acc_domain,
    input  logic [1:0]        acc_ap,
    input  logic              acc_xn,
    input  logic              acc_priv,
    input  logic [1:0]        acc_kind,
    output logic              acc_allow,
    output logic [1:0]        acc_fault
);
    logic [CTRL_W-1:0]   ctl_q;
    dpc_pkg::dom_mode_e  sel_mode;
    logic                perm_ok;
    logic                xn_hit;

    dpc_ctl_reg #(.W(CTRL_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en),
        .wr_data(ctl_wr_data), .q(ctl_q)
    );

    dpc_mode_mux #(.DOMAINS(DOMAINS)) u_mux (
        .ctl(ctl_q), .dom_idx(acc_domain), .mode(sel_mode)
    );

    dpc_perm_eval u_perm (
        .ap(acc_ap), .xn(acc_xn), .priv(acc_priv), .kind(acc_kind),
        .perm_ok(perm_ok), .xn_hit(xn_hit)
    );

    dpc_fault_pick u_pick (
        .mode(sel_mode), .perm_ok(perm_ok), .xn_hit(xn_hit),
        .fault(acc_fault), .allow(acc_allow)
    );
endmodule

// File: rtl/dpc_check.sv
// Module: assertion checker for dom_perm_gate, attached by bind.
// Relates the control word and the access inputs to the decision outputs.
module dpc_check #(
    parameter int DOMAINS = 16,
    localparam int DOM_W  = (DOMAINS > 1) ? $clog2(DOMAINS) : 1,
    localparam int CTRL_W = 2 * DOMAINS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr_en,
    input logic [CTRL_W-1:0] ctl_wr_data,
    input logic [CTRL_W-1:0] ctl_q,
    input logic [DOM_W-1:0]  acc_domain,
    input logic [1:0]        acc_ap,
    input logic              acc_xn,
    input logic              acc_priv,
    input logic [1:0]        acc_kind,
    input logic              acc_allow,
    input logic [1:0]        acc_fault
);
    logic [1:0] m;

    // Mode field of the addressed domain, as seen by the checker.
    always_comb m = ctl_q[{acc_domain, 1'b0} +: 2];

    p_reset_clear_r2: assert property (@(posedge clk)
        !rst_n |=> ctl_q == '0);

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> ctl_q == $past(ctl_wr_data));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr_en |=> $stable(ctl_q));

    p_deny_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'b00 || m == 2'b10) |-> (acc_fault == 2'b01 && !acc_allow));

    p_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'b11) |-> (acc_allow && acc_fault == 2'b00));

    p_noaccess_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'b01 && acc_ap == 2'b00) |-> acc_fault == 2'b10);

    p_privonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'b01 && acc_ap == 2'b01 && !acc_priv) |-> acc_fault == 2'b10);

    p_userwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'b01 && acc_ap == 2'b10 && !acc_priv && acc_kind == 2'b01)
        |-> acc_fault == 2'b10);

    p_xn_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'b01 && acc_ap == 2'b11 && acc_kind == 2'b10 && acc_xn)
        |-> acc_fault == 2'b11);

    p_allow_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_allow == (acc_fault == 2'b00));
endmodule

bind dom_perm_gate dpc_check #(.DOMAINS(DOMAINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_data(ctl_wr_data), .ctl_q(ctl_q), .acc_domain(acc_domain),
    .acc_ap(acc_ap), .acc_xn(acc_xn), .acc_priv(acc_priv),
    .acc_kind(acc_kind), .acc_allow(acc_allow), .acc_fault(acc_fault)
);

// File: tb/sim_dom_perm_gate.sv
// Bench: table of access vectors against a fixed control word, then directed
// tests for reset, write latency, write hold and table-wide code consistency.
module sim_dom_perm_gate;
    localparam int DOMAINS = 16;
    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic [3:0]  acc_domain = '0;
    logic [1:0]  acc_ap = '0;
    logic        acc_xn = 1'b0;
    logic        acc_priv = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        acc_allow;
    logic [1:0]  acc_fault;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dom_perm_gate #(.DOMAINS(DOMAINS)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en),
        .ctl_wr_data(ctl_wr_data), .acc_domain(acc_domain),
        .acc_ap(acc_ap), .acc_xn(acc_xn), .acc_priv(acc_priv),
        .acc_kind(acc_kind), .acc_allow(acc_allow), .acc_fault(acc_fault)
    );

    // Modes: d0 check, d1 all, d2 deny, d3 reserved, d4..d14 check, d15 all.
    localparam logic [31:0] CTL_WORD = 32'hD555_558D;

    // {req[3:0], dom[3:0], ap[1:0], xn, priv, kind[1:0], allow, code[1:0]}
    localparam logic [16:0] VEC [NV] = '{
        {4'd3,  4'd2,  2'b11, 1'b0, 1'b1, 2'b00, 1'b0, 2'b01}, // R3 deny
        {4'd3,  4'd3,  2'b11, 1'b0, 1'b1, 2'b10, 1'b0, 2'b01}, // R3 reserved
        {4'd3,  4'd2,  2'b00, 1'b1, 1'b0, 2'b01, 1'b0, 2'b01}, // R3 deny
        {4'd4,  4'd1,  2'b00, 1'b1, 1'b0, 2'b10, 1'b1, 2'b00}, // R4 all
        {4'd4,  4'd15, 2'b01, 1'b0, 1'b0, 2'b01, 1'b1, 2'b00}, // R4 top field
        {4'd5,  4'd0,  2'b00, 1'b0, 1'b1, 2'b00, 1'b0, 2'b10}, // R5
        {4'd5,  4'd4,  2'b00, 1'b1, 1'b0, 2'b10, 1'b0, 2'b10}, // R5
        {4'd6,  4'd0,  2'b01, 1'b0, 1'b1, 2'b01, 1'b1, 2'b00}, // R6
        {4'd6,  4'd0,  2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 2'b10}, // R6
        {4'd7,  4'd5,  2'b10, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00}, // R7
        {4'd7,  4'd5,  2'b10, 1'b0, 1'b0, 2'b01, 1'b0, 2'b10}, // R7
        {4'd7,  4'd5,  2'b10, 1'b0, 1'b0, 2'b10, 1'b1, 2'b00}, // R7
        {4'd7,  4'd5,  2'b10, 1'b0, 1'b1, 2'b01, 1'b1, 2'b00}, // R7
        {4'd8,  4'd6,  2'b11, 1'b0, 1'b0, 2'b01, 1'b1, 2'b00}, // R8
        {4'd9,  4'd7,  2'b11, 1'b1, 1'b0, 2'b10, 1'b0, 2'b11}, // R9 xn
        {4'd9,  4'd7,  2'b11, 1'b1, 1'b1, 2'b00, 1'b1, 2'b00}, // R9 read
        {4'd9,  4'd8,  2'b01, 1'b1, 1'b0, 2'b10, 1'b0, 2'b10}, // R9 order
        {4'd10, 4'd5,  2'b10, 1'b0, 1'b0, 2'b11, 1'b0, 2'b10}, // R10
        {4'd10, 4'd5,  2'b10, 1'b0, 1'b1, 2'b11, 1'b1, 2'b00}  // R10
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] d, input logic [1:0] ap,
                         input logic xn, input logic pr, input logic [1:0] k);
        acc_domain = d; acc_ap = ap; acc_xn = xn; acc_priv = pr; acc_kind = k;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R2: after reset every domain refuses access
        drive(4'd1, 2'b11, 1'b0, 1'b1, 2'b00);
        #1 check(acc_fault == 2'b01, "R2 reset deny", acc_fault, 1);
        check(acc_allow == 1'b0, "R2 reset allow", acc_allow, 0);

        // R1: write takes effect only after the edge
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = CTL_WORD;
        #1 check(acc_fault == 2'b01, "R1 before edge", acc_fault, 1);
        @(negedge clk) ctl_wr_en = 1'b0;
        #1 check(acc_allow == 1'b1, "R1 after edge", acc_allow, 1);

        // R1: data change without strobe is ignored
        @(negedge clk) ctl_wr_data = 32'h0;
        @(negedge clk) #1 check(acc_allow == 1'b1, "R1 hold", acc_allow, 1);

        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            v = VEC[i];
            @(negedge clk);
            drive(v[12:9], v[8:7], v[6], v[5], v[4:3]);
            #1;
            n_checks++;
            if (acc_fault != v[1:0] || acc_allow != v[2]) begin
                n_fail++;
                $display("FAIL R%0d vec %0d: actual allow %0b code %0b expected allow %0b code %0b",
                         v[16:13], i, acc_allow, acc_fault, v[2], v[1:0]);
            end
            // R11: allow tracks a zero fault code
            check(acc_allow == (acc_fault == 2'b00), "R11 allow/code", acc_allow, acc_fault == 2'b00);
        end

        // R2: reset mid-run clears the control word again
        drive(4'd1, 2'b00, 1'b0, 1'b0, 2'b00);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1 check(acc_fault == 2'b01, "R2 mid-run reset", acc_fault, 1);

        done = 1'b1;
        finish_run();
    end
endmodule